// File: doc/BRIEF.md
# Deferred Condition-Flag Evaluator

This block keeps a compact record of the most recent flag-affecting operation instead of producing condition flags eagerly. A write stores three things: a 3-bit operation-kind code, a source value and a result value. The flags are only rebuilt when someone asks for them. A query returns either the whole flag word or only the carry flag, and it does so combinationally from the stored record.

The supported kinds are an explicitly saved flag word, multiply at 8, 16 and 32 bits, and add at 8, 16 and 32 bits. The code 0 means that no valid record is held. This is the state after reset, and querying it reports an error. A query in the same cycle as a write sees the record from before the write.

The flag word is 12 bits wide and uses these positions: carry bit 0, parity bit 2, adjust bit 4, zero bit 6, sign bit 7, overflow bit 11.

Top module: `lazy_flags`

## Requirements
- R1: Kind codes are 0 for no record, 1 for an explicit flag word, 2/3/4 for multiply at 8/16/32 bits and 5/6/7 for add at 8/16/32 bits. The multiply and add codes are the base code plus a size index of 0, 1 or 2.
- R2: When `wrEn` is high, kind, source and result are captured on the rising clock edge. When `wrEn` is low, the stored record is held. A query in the same cycle as a write returns flags computed from the previous record.
- R3: For the explicit kind, a full query returns source bits [11:0] and a carry-only query returns source bit 0.
- R4: For multiply kinds, carry is 1 exactly when the full 32-bit stored source is nonzero, whatever the width. Overflow equals carry and adjust is 0.
- R5: For multiply kinds, zero and sign come from the stored result truncated to the kind's width. Parity is 1 when bits [7:0] of the result hold an even number of ones.
- R6: For add kinds, carry is 1 when the truncated result is unsigned-less-than the truncated source (the first operand).
- R7: For add kinds, the second operand is recovered as truncated result minus truncated source. Overflow is 1 when the two operands share a sign and the result's sign differs from it. Adjust is bit 4 of result XOR source XOR second operand.
- R8: For add kinds, zero, sign and parity follow the same rules as in R5.
- R9: A query of kind 0 returns an all-zero flag word and raises `errOut`. `errOut` is low for every other kind and whenever `qryValid` is low.
- R10: A carry-only query (`qryFull` low) returns the carry in bit 0 with every other bit 0. With `qryValid` low, `flagsOut` is 0.
- R11: After reset the stored kind is 0, so a query raises `errOut`.
- R12: For multiply and add kinds, the bits of the full flag word other than positions 0, 2, 4, 6, 7 and 11 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Capture a new record |
| wrKind | input | 3 | Operation-kind code to store |
| wrSrc | input | 32 | Source value to store |
| wrDst | input | 32 | Result value to store |
| qryValid | input | 1 | Query request |
| qryFull | input | 1 | 1 returns the full flag word, 0 returns carry only |
| flagsOut | output | 12 | Reconstructed flags |
| errOut | output | 1 | Query hit the no-record kind |

## Verification
A written record is first visible on the query port in the cycle that follows its capturing edge. The query path itself adds no register, so the flags answer within the same cycle as the request. The bench therefore drives each write before a rising edge and sets the query after the next falling edge. It then samples both query forms a fraction of a nanosecond later, well away from any edge. For the same-cycle case, the bench raises the write and the query together and samples before the edge, where the old flags are due, and again after the edge, where the new ones are due.

// File: rtl/lazy_flags_pkg.sv
package lazy_flags_pkg;

  localparam int FLAG_W = 12;
  localparam int KIND_W = 3;

  localparam int POS_CARRY  = 0;
  localparam int POS_PARITY = 2;
  localparam int POS_ADJUST = 4;
  localparam int POS_ZERO   = 6;
  localparam int POS_SIGN   = 7;
  localparam int POS_OVFL   = 11;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE  = 3'd0,
    KIND_EXPL  = 3'd1,
    KIND_MUL8  = 3'd2,
    KIND_MUL16 = 3'd3,
    KIND_MUL32 = 3'd4,
    KIND_ADD8  = 3'd5,
    KIND_ADD16 = 3'd6,
    KIND_ADD32 = 3'd7
  } kind_e;

  typedef struct packed {
    logic       isNone;
    logic       isExpl;
    logic       isMul;
    logic       isAdd;
    logic [1:0] sizeIdx;
  } strobe_t;

  function automatic logic [FLAG_W-1:0] packFlags(
    input logic c, input logic p, input logic a,
    input logic z, input logic s, input logic o);
    logic [FLAG_W-1:0] w;
    w = '0;
    w[POS_CARRY]  = c;
    w[POS_PARITY] = p;
    w[POS_ADJUST] = a;
    w[POS_ZERO]   = z;
    w[POS_SIGN]   = s;
    w[POS_OVFL]   = o;
    return w;
  endfunction

endpackage

// File: rtl/lazy_flags_ctrl.sv
module lazy_flags_ctrl
  import lazy_flags_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [KIND_W-1:0] wrKind,
  output strobe_t           strobe
);

  kind_e kindQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    kindQ <= KIND_NONE;
    else if (wrEn) kindQ <= kind_e'(wrKind);
  end

  always_comb begin
    strobe = '0;
    unique case (kindQ)
      KIND_NONE: strobe.isNone = 1'b1;
      KIND_EXPL: strobe.isExpl = 1'b1;
      KIND_MUL8, KIND_MUL16, KIND_MUL32: begin
        strobe.isMul   = 1'b1;
        strobe.sizeIdx = 2'(kindQ - KIND_MUL8);
      end
      default: begin
        strobe.isAdd   = 1'b1;
        strobe.sizeIdx = 2'(kindQ - KIND_ADD8);
      end
    endcase
  end

  p_capture_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> kindQ == $past(wrKind));

  p_hold_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(kindQ));

  p_size_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.sizeIdx != 2'd3);

endmodule

// File: rtl/lazy_flags_dp.sv
module lazy_flags_dp
  import lazy_flags_pkg::*;
#(
  parameter int LONG_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [LONG_W-1:0] wrSrc,
  input  logic [LONG_W-1:0] wrDst,
  input  strobe_t           strobe,
  input  logic              qryValid,
  input  logic              qryFull,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              errOut
);

  localparam int N_SIZES = 3;

  logic [LONG_W-1:0] srcQ, dstQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcQ <= '0;
      dstQ <= '0;
    end else if (wrEn) begin
      srcQ <= wrSrc;
      dstQ <= wrDst;
    end
  end

  logic [N_SIZES-1:0] zeroV, signV, addCarry, addOvfl, addAdj;

  for (genvar gi = 0; gi < N_SIZES; gi++) begin : g_size
    localparam int W = LONG_W >> (N_SIZES - 1 - gi);
    logic [W-1:0] resT, srcT, opbT;
    assign resT         = dstQ[W-1:0];
    assign srcT         = srcQ[W-1:0];
    assign opbT         = resT - srcT;
    assign zeroV[gi]    = (resT == '0);
    assign signV[gi]    = resT[W-1];
    assign addCarry[gi] = (resT < srcT);
    assign addOvfl[gi]  = (srcT[W-1] == opbT[W-1]) && (resT[W-1] != srcT[W-1]);
    assign addAdj[gi]   = resT[4] ^ srcT[4] ^ opbT[4];
  end

  logic parityEven, mulCarry, selZero, selSign;
  logic carryBit;
  logic [FLAG_W-1:0] fullWord;

  assign parityEven = ~^dstQ[7:0];
  assign mulCarry   = |srcQ;
  assign selZero    = zeroV[strobe.sizeIdx];
  assign selSign    = signV[strobe.sizeIdx];

  always_comb begin
    carryBit = 1'b0;
    fullWord = '0;
    if (strobe.isExpl) begin
      carryBit = srcQ[0];
      fullWord = srcQ[FLAG_W-1:0];
    end else if (strobe.isMul) begin
      carryBit = mulCarry;
      fullWord = packFlags(mulCarry, parityEven, 1'b0, selZero, selSign, mulCarry);
    end else if (strobe.isAdd) begin
      carryBit = addCarry[strobe.sizeIdx];
      fullWord = packFlags(addCarry[strobe.sizeIdx], parityEven, addAdj[strobe.sizeIdx],
                           selZero, selSign, addOvfl[strobe.sizeIdx]);
    end
  end

  always_comb begin
    errOut   = qryValid && strobe.isNone;
    flagsOut = '0;
    if (qryValid && !strobe.isNone)
      flagsOut = qryFull ? fullWord : {{(FLAG_W-1){1'b0}}, carryBit};
  end

  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    errOut |-> flagsOut == '0);

  p_carry_only_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (qryValid && !qryFull) |-> flagsOut[FLAG_W-1:1] == '0);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !qryValid |-> (flagsOut == '0 && !errOut));

  p_mul_ovfl_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qryValid && qryFull && strobe.isMul) |->
      (flagsOut[POS_OVFL] == flagsOut[POS_CARRY] && !flagsOut[POS_ADJUST]));

  p_zero_not_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (qryValid && qryFull && (strobe.isMul || strobe.isAdd) && flagsOut[POS_ZERO])
      |-> !flagsOut[POS_SIGN]);

  p_spare_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (qryValid && (strobe.isMul || strobe.isAdd)) |->
      (flagsOut & 12'b0111_0010_1010) == '0);

endmodule

// File: rtl/lazy_flags.sv
module lazy_flags
  import lazy_flags_pkg::*;
#(
  parameter int LONG_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [KIND_W-1:0] wrKind,
  input  logic [LONG_W-1:0] wrSrc,
  input  logic [LONG_W-1:0] wrDst,
  input  logic              qryValid,
  input  logic              qryFull,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              errOut
);

  strobe_t strobe;

  lazy_flags_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrKind (wrKind),
    .strobe (strobe)
  );

  lazy_flags_dp #(.LONG_W(LONG_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrSrc    (wrSrc),
    .wrDst    (wrDst),
    .strobe   (strobe),
    .qryValid (qryValid),
    .qryFull  (qryFull),
    .flagsOut (flagsOut),
    .errOut   (errOut)
  );

endmodule

// File: tb/lazy_flags_bench.sv
`timescale 1ns/1ps
module lazy_flags_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrKind = '0;
  logic [31:0] wrSrc = '0, wrDst = '0;
  logic        qryValid = 1'b0, qryFull = 1'b0;
  logic [11:0] flagsOut;
  logic        errOut;

  int nChk = 0, nBad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lazy_flags u_lazy_flags (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrKind(wrKind),
    .wrSrc(wrSrc), .wrDst(wrDst), .qryValid(qryValid), .qryFull(qryFull),
    .flagsOut(flagsOut), .errOut(errOut));

  function automatic logic [12:0] model(input int kind, input logic [31:0] s,
                                        input logic [31:0] d, input bit full);
    int w;
    logic [31:0] m, rs, ss, bs;
    bit c, p, a, z, sg, o;
    logic [11:0] f;
    if (kind == 0) return {1'b1, 12'h000};
    if (kind == 1) return {1'b0, full ? s[11:0] : {11'b0, s[0]}};
    w  = (kind <= 4) ? (8 << (kind - 2)) : (8 << (kind - 5));
    m  = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    rs = d & m; ss = s & m; bs = (rs - ss) & m;
    p  = ($countones(d[7:0]) % 2) == 0;
    z  = (rs == 0);
    sg = rs[w-1];
    if (kind <= 4) begin
      c = (s != 0); o = c; a = 0;
    end else begin
      c = rs < ss;
      o = (ss[w-1] == bs[w-1]) && (rs[w-1] != ss[w-1]);
      a = rs[4] ^ ss[4] ^ bs[4];
    end
    f = 12'(c) | (12'(p) << 2) | (12'(a) << 4) | (12'(z) << 6) | (12'(sg) << 7) | (12'(o) << 11);
    return {1'b0, full ? f : {11'b0, c}};
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got err=%0b flags=%03h, want err=%0b flags=%03h",
               tag, act[12], act[11:0], exp[12], exp[11:0]);
    end
  endtask

  task automatic doWrite(input int kind, input logic [31:0] s, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrKind = 3'(kind); wrSrc = s; wrDst = d; qryValid = 0;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic probe(input string tagFull, input string tagCarry,
                       input int kind, input logic [31:0] s, input logic [31:0] d);
    @(negedge clk);
    qryValid = 1; qryFull = 1; #0.5;
    check(tagFull, {errOut, flagsOut}, model(kind, s, d, 1));
    qryFull = 0; #0.5;
    check(tagCarry, {errOut, flagsOut}, model(kind, s, d, 0));
    qryValid = 0; #0.5;
    check("R10 idle", {errOut, flagsOut}, 13'h0);
  endtask

  task automatic op(input string tf, input string tc, input int kind,
                    input logic [31:0] s, input logic [31:0] d);
    doWrite(kind, s, d);
    probe(tf, tc, kind, s, d);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nBad++; nChk++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R11: reset leaves kind 0 -> error, zero flags
    probe("R11 reset full", "R11 reset carry", 0, 0, 0);

    // R3: explicit flag word
    for (int i = 0; i < 300; i++) begin
      logic [31:0] v = $urandom;
      op("R3 expl full", "R3 expl carry", 1, v, $urandom);
    end

    // R9: explicit write of kind 0
    op("R9 none full", "R9 none carry", 0, 32'h1234, 32'h5678);

    // R6 R7 R8: 8-bit add sweep, upper garbage bits must be ignored (R1 code 5)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 7) begin
        logic [31:0] up = $urandom & 32'hFFFF_FF00;
        op("R7 add8 full", "R6 add8 carry", 5, up | 32'(a), (up ^ 32'hA5A5_0000) | 32'((a + b) & 8'hFF));
      end

    // R4 R5: 8-bit multiply sweep (R1 code 2)
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 3) begin
        logic [15:0] pr = 16'(a * b);
        op("R5 mul8 full", "R4 mul8 carry", 2, {24'h0, pr[15:8]}, {16'hBEEF, pr});
      end

    // R4: multiply carry looks at all 32 source bits, even for byte kind
    op("R4 mul8 hi src full", "R4 mul8 hi src carry", 2, 32'h8000_0000, 32'h0);
    op("R4 mul8 zero src full", "R4 mul8 zero src carry", 2, 32'h0, 32'hFFFF_FF00);

    // R12 R8: wider widths (R1 codes 3,4,6,7)
    for (int i = 0; i < 1000; i++) begin
      logic [31:0] x = $urandom, y = $urandom;
      op("R12 add16 full", "R6 add16 carry", 6, x, x + (y & 32'hFFFF));
      op("R12 add32 full", "R6 add32 carry", 7, x, x + y);
      op("R12 mul16 full", "R4 mul16 carry", 3, (i % 3 == 0) ? 32'h0 : y, x);
      op("R12 mul32 full", "R4 mul32 carry", 4, (i % 4 == 0) ? 32'h0 : y, x);
    end
    // R8: add corner cases: zero result with carry, signed overflow
    op("R8 add32 wrap zero", "R6 add32 wrap carry", 7, 32'hFFFF_FFFF, 32'h0);
    op("R7 add16 ovfl", "R6 add16 ovfl carry", 6, 32'h7FFF, 32'h8000);
    op("R7 add8 neg ovfl", "R6 add8 neg carry", 5, 32'h80, 32'h00);

    // R2: same-cycle write and query sees the old record, then the new one
    doWrite(1, 32'h0000_0ACD, 32'h0);
    @(negedge clk);
    wrEn = 1; wrKind = 3'd1; wrSrc = 32'h0000_0010; wrDst = '0;
    qryValid = 1; qryFull = 1; #0.5;
    check("R2 old record", {errOut, flagsOut}, {1'b0, 12'hACD});
    @(posedge clk); #1;
    wrEn = 0;
    check("R2 new record", {errOut, flagsOut}, {1'b0, 12'h010});
    // R2: hold without wrEn
    @(negedge clk);
    wrKind = 3'd0; wrSrc = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    check("R2 hold", {errOut, flagsOut}, {1'b0, 12'h010});
    qryValid = 0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule